// File: doc/BRIEF.md
# Watchdog Timer with Grace Window and Reset Pulse

This block watches for software that has stopped responding. After software enables it, an 18-bit up-counter runs on the watchdog clock. When the counter has run for the selected interval, the block sets an interrupt flag, which can drive an interrupt line. It then opens a fixed grace window of 1024 clocks. If software does not restart the watchdog before the window closes, the block sets a sticky reset-cause flag and drives a system-reset output for 64 clocks. After that pulse the counter starts again from zero.

Software reaches the block through a single write strobe with a control word and through a read-back status word. The interval is a power-of-four choice made by a 3-bit field, from 16 clocks up to 2^18 clocks. The reset-cause flag outlives the reset pulse that the watchdog itself drives, so boot code can find out why the system restarted. Only the power-on reset input clears it, apart from a software clear.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rd_data` reads 0 and both `irq_o` and `sys_rst_o` are low.
- R2: A write with `wr_en`=1 loads enable from `wr_data[0]`, interrupt enable from `wr_data[1]` and interval select `sel` from `wr_data[4:2]`. These read back at the same positions of `rd_data`. The counter runs only while enable is 1. The interrupt flag reads 1 exactly 2^(2*sel+4) clocks after the clock edge that performed the enabling write.
- R3: The interrupt flag reads at `rd_data[6]` and stays set until cleared. `irq_o` is high exactly when the flag is set and interrupt enable is 1.
- R4: If no restart happens, `sys_rst_o` rises and the reset flag (`rd_data[7]`) sets exactly 2^(2*sel+4)+1024 clocks after the enabling write.
- R5: Writing 1 to `wr_data[5]` (restart) sets the restart bit (`rd_data[5]`). One clock later the counter and any open grace window are cleared and the bit reads 0 again. Restarting more often than the interval keeps the interrupt flag and `sys_rst_o` low.
- R6: `sys_rst_o` stays high for exactly 64 clocks and then goes low.
- R7: The reset flag stays set through and after the reset pulse. Writing 1 to `wr_data[7]` clears the reset flag, and writing 1 to `wr_data[6]` clears the interrupt flag.
- R8: Writing enable=0 clears the counter and cancels an open grace window, so no reset follows. A reset pulse already in progress still runs its full 64 clocks.
- R9: The counter holds at zero during the reset pulse and restarts counting afterwards. With enable still 1, the next reset pulse rises exactly 2^(2*sel+4)+1024 clocks after `sys_rst_o` falls.
- R10: A restart whose effect lands in the deadline clock wins, and no reset is generated. A restart one clock later does not prevent the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Active-low power-on reset, clears all state |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word: enable, interrupt enable, select, restart, flag clears |
| rd_data | output | 8 | Status word: enable, interrupt enable, select, restart pending, interrupt flag, reset flag |
| irq_o | output | 1 | Interrupt request |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
A write takes effect on `rd_data` at the clock edge that samples it. The interrupt flag is due 2^(2*sel+4) edges after the enabling write, the reset pulse 1024 edges after that, and the restart bit clears one edge after it was set. The bench keeps a behavioural model that takes the same edge and compares every output at the falling edge that follows. The directed checks count falling edges from the write or from the fall of the pulse, so each measured delay equals the number of edges in the requirement. The restart-priority case places the restart write so that it lands in the deadline clock, and then one clock later, to test both sides of the boundary.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    // Control/status word field positions
    localparam int F_EN  = 0;
    localparam int F_IE  = 1;
    localparam int F_SEL = 2;

    function automatic int f_kick(input int sel_w);
        return F_SEL + sel_w;
    endfunction

    function automatic int f_clr_irq(input int sel_w);
        return F_SEL + sel_w + 1;
    endfunction

    function automatic int f_clr_rst(input int sel_w);
        return F_SEL + sel_w + 2;
    endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W+4:0] wr_data,
    input  logic             irq_evt_i,
    input  logic             fire_evt_i,
    output logic             en_o,
    output logic             ie_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             restart_o,
    output logic             irq_flag_o,
    output logic             rst_flag_o
);
    import wdog_pkg::*;

    localparam int K_KICK = f_kick(SEL_W);
    localparam int K_CIRQ = f_clr_irq(SEL_W);
    localparam int K_CRST = f_clr_rst(SEL_W);

    typedef struct packed {
        logic             en;
        logic             ie;
        logic [SEL_W-1:0] sel;
        logic             restart;
        logic             irqf;
        logic             rstf;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.restart = 1'b0;
        if (wr_en) begin
            s_d.en      = wr_data[F_EN];
            s_d.ie      = wr_data[F_IE];
            s_d.sel     = wr_data[F_SEL +: SEL_W];
            s_d.restart = wr_data[K_KICK];
            if (wr_data[K_CIRQ]) s_d.irqf = 1'b0;
            if (wr_data[K_CRST]) s_d.rstf = 1'b0;
        end
        // hardware set wins over a software clear in the same cycle
        if (irq_evt_i)  s_d.irqf = 1'b1;
        if (fire_evt_i) s_d.rstf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o       = s_q.en;
    assign ie_o       = s_q.ie;
    assign sel_o      = s_q.sel;
    assign restart_o  = s_q.restart;
    assign irq_flag_o = s_q.irqf;
    assign rst_flag_o = s_q.rstf;

    AST_RSTF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fire_evt_i |=> s_q.rstf); // R4
    AST_RSTF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rstf && !(wr_en && wr_data[K_CRST])) |=> s_q.rstf); // R7
    AST_KICK_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.restart && !(wr_en && wr_data[K_KICK])) |=> !s_q.restart); // R5
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W    = 18,
    parameter int SEL_W    = 3,
    parameter int TAP_BASE = 4,
    parameter int TAP_STEP = 2,
    parameter int GRACE    = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             restart_i,
    input  logic             hold_i,
    output logic             irq_evt_o,
    output logic             fire_evt_o
);
    localparam int N_SEL   = 1 << SEL_W;
    localparam int GRACE_W = (GRACE > 1) ? $clog2(GRACE) : 1;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [GRACE_W-1:0] grace;
        logic               in_grace;
    } cnt_t;

    cnt_t c_d, c_q;
    logic [CNT_W-1:0] mask_tab [N_SEL];
    logic [CNT_W-1:0] mask;

    for (genvar g = 0; g < N_SEL; g++) begin : g_tap
        localparam int SH = TAP_BASE + TAP_STEP * g;
        assign mask_tab[g] = ~({CNT_W{1'b1}} << SH);
    end

    assign mask = mask_tab[sel_i];

    always_comb begin
        c_d        = c_q;
        irq_evt_o  = 1'b0;
        fire_evt_o = 1'b0;
        if (hold_i || restart_i || !en_i) begin
            c_d = '0;
        end else if (c_q.in_grace) begin
            if (c_q.grace == GRACE_W'(GRACE - 1)) begin
                fire_evt_o = 1'b1;
                c_d        = '0;
            end else begin
                c_d.grace = c_q.grace + 1'b1;
            end
        end else if ((c_q.cnt & mask) == mask) begin
            irq_evt_o  = 1'b1;
            c_d.cnt    = '0;
            c_d.in_grace = 1'b1;
        end else begin
            c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    AST_IRQ_STARTS_GRACE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt_o |=> c_q.in_grace); // R3
    AST_KICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |-> !fire_evt_o); // R10
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (c_q.cnt == '0 && !c_q.in_grace)); // R5
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (c_q.cnt == '0 && !c_q.in_grace)); // R8
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_evt_o, fire_evt_o})); // R4
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (c_q.cnt == '0)); // R9
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int PULSE_LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic active_o
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (p_q.left != '0)  p_d.left = p_q.left - 1'b1;
        else if (fire_i)     p_d.left = PW'(PULSE_LEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign active_o = (p_q.left != '0);

    // checker: length of the high phase
    logic [PW-1:0] chk_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        chk_len <= '0;
        else if (active_o) chk_len <= chk_len + 1'b1;
        else               chk_len <= '0;
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> (chk_len == PW'(PULSE_LEN))); // R6
    AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> !fire_i); // R6
    AST_FIRE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && !active_o) |=> active_o); // R4
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int CNT_W     = 18,
    parameter int SEL_W     = 3,
    parameter int TAP_BASE  = 4,
    parameter int TAP_STEP  = 2,
    parameter int GRACE     = 1024,
    parameter int PULSE_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W+4:0] wr_data,
    output logic [SEL_W+4:0] rd_data,
    output logic             irq_o,
    output logic             sys_rst_o
);
    logic             en, ie, restart, irq_flag, rst_flag;
    logic [SEL_W-1:0] sel;
    logic             irq_evt, fire_evt, pulse_on;

    wdog_regs #(.SEL_W(SEL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .irq_evt_i  (irq_evt),
        .fire_evt_i (fire_evt),
        .en_o       (en),
        .ie_o       (ie),
        .sel_o      (sel),
        .restart_o  (restart),
        .irq_flag_o (irq_flag),
        .rst_flag_o (rst_flag)
    );

    wdog_count #(
        .CNT_W    (CNT_W),
        .SEL_W    (SEL_W),
        .TAP_BASE (TAP_BASE),
        .TAP_STEP (TAP_STEP),
        .GRACE    (GRACE)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .sel_i      (sel),
        .restart_i  (restart),
        .hold_i     (pulse_on),
        .irq_evt_o  (irq_evt),
        .fire_evt_o (fire_evt)
    );

    wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire_evt),
        .active_o (pulse_on)
    );

    assign rd_data   = {rst_flag, irq_flag, restart, sel, ie, en};
    assign irq_o     = irq_flag & ie;
    assign sys_rst_o = pulse_on;

    AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt |=> irq_flag); // R3
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
    localparam int CLK_P = 10;
    localparam int GR    = 1024;
    localparam int PL    = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_o, sys_rst_o;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;

    // behavioural model state
    int m_cnt = 0, m_grace = -1, m_pulse = 0, m_sel = 0;
    bit m_en = 0, m_ie = 0, m_rs = 0, m_irqf = 0, m_rstf = 0;

    wdog_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .irq_o     (irq_o),
        .sys_rst_o (sys_rst_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int intv;
        bit fire, iset;
        if (!rst_n) begin
            m_cnt = 0; m_grace = -1; m_pulse = 0; m_sel = 0;
            m_en = 0; m_ie = 0; m_rs = 0; m_irqf = 0; m_rstf = 0;
        end else begin
            intv = 1 << (4 + 2 * m_sel);
            fire = 0; iset = 0;
            if (m_pulse > 0) begin
                m_pulse--; m_cnt = 0; m_grace = -1;
            end else if (m_rs || !m_en) begin
                m_cnt = 0; m_grace = -1;
            end else if (m_grace >= 0) begin
                if (m_grace == GR - 1) begin
                    fire = 1; m_grace = -1; m_pulse = PL; m_cnt = 0;
                end else m_grace++;
            end else if (m_cnt % intv == intv - 1) begin
                iset = 1; m_grace = 0; m_cnt = 0;
            end else m_cnt = (m_cnt + 1) % (1 << 18);
            if (wr_en && wr_data[6]) m_irqf = 0;
            if (iset) m_irqf = 1;
            if (wr_en && wr_data[7]) m_rstf = 0;
            if (fire) m_rstf = 1;
            m_rs = wr_en && wr_data[5];
            if (wr_en) begin
                m_en = wr_data[0]; m_ie = wr_data[1]; m_sel = int'(wr_data[4:2]);
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R2 ctrl", int'(rd_data[4:0]), int'({m_sel[2:0], m_ie, m_en}));
            check("R5 restart", int'(rd_data[5]), int'(m_rs));
            check("R3 flag", int'(rd_data[6]), int'(m_irqf));
            check("R4 rstflag", int'(rd_data[7]), int'(m_rstf));
            check("R3 irq", int'(irq_o), int'(m_irqf & m_ie));
            check("R6 sysrst", int'(sys_rst_o), int'(m_pulse > 0));
        end
    end

    // caller is at a falling edge; returns at the next falling edge
    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    function automatic logic [7:0] ctl(input int sel, input bit ie, input bit en);
        return {3'b000, sel[2:0], ie, en};
    endfunction

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rd", int'(rd_data), 0);
        check("R1 irq", int'(irq_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd after", int'(rd_data), 0);
        check("R1 sysrst", int'(sys_rst_o), 0);
        cmp_on = 1'b1;

        // R2/R3: interval sel=0 -> 16 clocks
        wr(ctl(0, 1, 1));
        n = 0;
        while (!rd_data[6] && n < 5000) begin @(negedge clk); n++; end
        check("R2 irq delay sel0", n, 16);
        check("R3 irq out", int'(irq_o), 1);
        // R4: reset at 16+1024 after the write
        while (!sys_rst_o && n < 5000) begin @(negedge clk); n++; end
        check("R4 reset delay", n, 16 + GR);
        // R6 pulse width
        n = 0;
        while (sys_rst_o && n < 500) begin @(negedge clk); n++; end
        check("R6 pulse width", n, PL);
        check("R7 flag kept", int'(rd_data[7]), 1);
        // R9 next deadline counted from pulse end
        n = 0;
        while (!sys_rst_o && n < 5000) begin @(negedge clk); n++; end
        check("R9 restart after pulse", n, 16 + GR);
        // R8: disable mid-pulse, pulse still lasts 64
        repeat (9) @(negedge clk);
        wr(ctl(0, 1, 0));
        n = 10;
        while (sys_rst_o && n < 500) begin @(negedge clk); n++; end
        check("R8 pulse not cut", n, PL);
        // R7 W1C of both flags, then ie=0 gating
        wr(8'hC0);
        check("R7 flags cleared", int'(rd_data[7:6]), 0);
        repeat (1500) @(negedge clk);
        check("R8 stays idle", int'(sys_rst_o | rd_data[7]), 0);

        // R3: flag with interrupt enable off
        wr(ctl(1, 0, 1));
        n = 0;
        while (!rd_data[6] && n < 5000) begin @(negedge clk); n++; end
        check("R2 irq delay sel1", n, 64);
        check("R3 irq gated", int'(irq_o), 0);
        // R8: disable during grace cancels reset
        repeat (100) @(negedge clk);
        wr(8'h40 | ctl(1, 0, 0));
        repeat (1200) @(negedge clk);
        check("R8 grace cancelled", int'(sys_rst_o | rd_data[7]), 0);

        // R5: periodic restart keeps it quiet
        wr(ctl(1, 1, 1));
        for (int k = 0; k < 8; k++) begin
            repeat (38) @(negedge clk);
            wr(8'h20 | ctl(1, 1, 1));
            check("R5 restart bit set", int'(rd_data[5]), 1);
            @(negedge clk);
            check("R5 restart bit self-clears", int'(rd_data[5]), 0);
        end
        check("R5 no irq", int'(rd_data[6]), 0);
        wr(ctl(0, 1, 0));

        // R2 longer interval sel=2 -> 256
        wr(ctl(2, 1, 1));
        n = 0;
        while (!rd_data[6] && n < 5000) begin @(negedge clk); n++; end
        check("R2 irq delay sel2", n, 256);
        wr(8'h40 | ctl(0, 1, 0));

        // R10: restart lands on deadline clock -> no reset
        wr(ctl(0, 1, 1));
        repeat (GR + 14) @(negedge clk);
        wr(8'h20 | ctl(0, 1, 1));
        repeat (100) @(negedge clk);
        check("R10 kick on deadline", int'(sys_rst_o | rd_data[7]), 0);
        wr(8'h40 | ctl(0, 1, 0));

        // R10 boundary: one clock late -> reset happens
        wr(ctl(0, 1, 1));
        repeat (GR + 15) @(negedge clk);
        wr(8'h20 | ctl(0, 1, 1));
        check("R10 late kick resets", int'(sys_rst_o), 1);
        repeat (80) @(negedge clk);
        check("R10 late kick flag", int'(rd_data[7]), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule